// File: doc/BRIEF.md
# Dual-Clock Cell FIFO with Commit and Discard

This block carries fixed-size data cells from one clock domain to another. The two clocks are unrelated; one side may run near 104 MHz while the other runs near 50 MHz. The writer pushes one word per cycle. It closes each cell in one of two ways. A commit makes the cell eligible for reading. A discard throws away every word pushed since the last commit. Because of this, a cell that turns out to be bad on arrival never reaches the reader, not even in part.

The reader watches a single flag that says a whole cell is waiting. It then pops one word per cycle for the length of the cell. The writer watches a flag that says a whole cell of room is left. The cell length comes from a static byte-count input that is tied off on the board: an even value from 16 to 128, giving 8 to 64 words. Pointers cross between the domains in Gray code through multi-flop synchronisers.

Top module: `cellq_dual_clock`

## Requirements
- R1: During reset and right after it, `rd_cell_avail` is 0 and `wr_room` is 1.
- R2: Words pushed but not yet committed are never offered to the reader. A committed cell is read back word for word, in push order, once it has crossed to the read domain.
- R3: A `wr_discard` pulse returns the write position to the last commit point in one cycle. The discarded words are never read, and the next committed cell is read from its first word.
- R4: At a cell boundary, `rd_cell_avail` is 1 exactly when the number of committed, unread words is at least `cell_bytes/2`. Bit 0 of `cell_bytes` is ignored.
- R5: `wr_room` is 1 exactly when the storage depth minus the committed words not yet read is at least `cell_bytes/2`. Uncommitted words do not lower it.
- R6: A push into a full store is dropped, and no stored word is overwritten. With a depth of 128 words, pushing 130 words stores exactly the first 128.
- R7: A pop while no committed word is unread has no effect. The next committed cell still reads from its first word.
- R8: When `wr_commit` and `wr_discard` are both high in one cycle, the discard takes effect and the commit is ignored.
- R9: A commit that comes in the same cycle as a push includes that pushed word in the cell.
- R10: The cell threshold follows `cell_bytes`. At 128 bytes, 32 committed words do not raise `rd_cell_avail`, and 64 committed words do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Active-high asynchronous reset for both domains |
| cell_bytes | input | CELL_BYTES_W | Static cell length in bytes (even, 16..128) |
| wr_clk | input | 1 | Write-side clock |
| wr_push | input | 1 | Store `wr_data` this cycle |
| wr_data | input | DATA_W | Word to store |
| wr_commit | input | 1 | Close the current cell and make it readable |
| wr_discard | input | 1 | Drop all words since the last commit |
| wr_room | output | 1 | Space for one full cell remains |
| rd_clk | input | 1 | Read-side clock |
| rd_pop | input | 1 | Advance to the next word |
| rd_data | output | DATA_W | Word at the read position (show-ahead) |
| rd_cell_avail | output | 1 | At least one full committed cell is waiting |

## Verification
A wrong working or commit pointer shows up as a wrong word on `rd_data` the first time the affected cell is read back. This happens only after the commit has walked across the crossing, which takes up to one cell length of write cycles plus the synchroniser delay. A wrong read pointer or a bad synchroniser path shows up in the flags. `wr_room` or `rd_cell_avail` holds the wrong level after the crossing settles, or a later cell starts on an unexpected word. The bench therefore reads back every cell in full and samples the flags only after a fixed settling interval.

// File: rtl/cellq_pkg.sv
package cellq_pkg;
   localparam int unsigned MIN_CELL_WORDS = 8;
   localparam int unsigned MAX_CELL_WORDS = 64;

   // Cell length in words from a byte count; the odd bit is dropped.
   function automatic logic [7:0] bytes_to_words(input logic [7:0] nbytes);
      return {1'b0, nbytes[7:1]};
   endfunction
endpackage

// File: rtl/cellq_ram.sv
module cellq_ram #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 9
) (
   input  logic              wr_clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge wr_clk) begin
      if (we) mem_q[waddr] <= wdata;
   end

   // Show-ahead read: the word under the read pointer is always presented.
   assign rdata = mem_q[raddr];
endmodule

// File: rtl/cellq_gray_xfer.sv
module cellq_gray_xfer #(
   parameter int unsigned W      = 10,
   parameter int unsigned STAGES = 2
) (
   input  logic         src_clk,
   input  logic         dst_clk,
   input  logic         rst,
   input  logic [W-1:0] src_bin,
   output logic [W-1:0] dst_bin
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cellq_gray_xfer: STAGES must be at least 2");
   end
   if (W < 2) begin : g_bad_width
      $error("cellq_gray_xfer: W must be at least 2");
   end

   logic [W-1:0] src_gray_q;
   logic [W-1:0] chain_q [STAGES];

   always_ff @(posedge src_clk or posedge rst) begin
      if (rst) src_gray_q <= '0;
      else     src_gray_q <= src_bin ^ (src_bin >> 1);
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge dst_clk or posedge rst) begin
            if (rst) chain_q[s] <= '0;
            else     chain_q[s] <= src_gray_q;
         end
      end else begin : g_next
         always_ff @(posedge dst_clk or posedge rst) begin
            if (rst) chain_q[s] <= '0;
            else     chain_q[s] <= chain_q[s-1];
         end
      end
   end

   for (genvar b = 0; b < W; b++) begin : g_g2b
      assign dst_bin[b] = ^(chain_q[STAGES-1] >> b);
   end

   // R2
   gray_step_chk: assert property (@(posedge src_clk) disable iff (rst)
      $countones(src_gray_q ^ $past(src_gray_q)) <= 1);
endmodule

// File: rtl/cellq_dual_clock.sv
module cellq_dual_clock #(
   parameter int unsigned DATA_W       = 16,
   parameter int unsigned ADDR_W       = 9,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned CELL_BYTES_W = 8
) (
   input  logic                    rst,
   input  logic [CELL_BYTES_W-1:0] cell_bytes,
   input  logic                    wr_clk,
   input  logic                    wr_push,
   input  logic [DATA_W-1:0]       wr_data,
   input  logic                    wr_commit,
   input  logic                    wr_discard,
   output logic                    wr_room,
   input  logic                    rd_clk,
   input  logic                    rd_pop,
   output logic [DATA_W-1:0]       rd_data,
   output logic                    rd_cell_avail
);
   import cellq_pkg::*;

   localparam int unsigned PTR_W = ADDR_W + 1;
   localparam int unsigned CMP_W = (PTR_W > CELL_BYTES_W) ? PTR_W : CELL_BYTES_W;
   localparam logic [PTR_W-1:0] DEPTH_P = {1'b1, {ADDR_W{1'b0}}};

   if ((1 << ADDR_W) < MAX_CELL_WORDS) begin : g_bad_depth
      $error("cellq_dual_clock: depth must hold the largest cell");
   end
   if (CELL_BYTES_W != 8) begin : g_bad_cw
      $error("cellq_dual_clock: CELL_BYTES_W must be 8");
   end

   logic [CELL_BYTES_W-1:0] cell_words;
   assign cell_words = bytes_to_words(cell_bytes);

   // ---------------- write domain ----------------
   logic [PTR_W-1:0] wptr, wcptr, pub_ptr, rq_bin;
   logic [PTR_W-1:0] work_cnt, commit_cnt, free_cnt, wptr_adv;
   logic             push_ok;

   assign work_cnt   = wptr - rq_bin;
   assign commit_cnt = wcptr - rq_bin;
   assign free_cnt   = DEPTH_P - commit_cnt;
   assign push_ok    = wr_push && !wr_discard && (work_cnt != DEPTH_P);
   assign wptr_adv   = wptr + {{(PTR_W-1){1'b0}}, push_ok};
   assign wr_room    = CMP_W'(free_cnt) >= CMP_W'(cell_words);

   always_ff @(posedge wr_clk or posedge rst) begin
      if (rst) begin
         wptr    <= '0;
         wcptr   <= '0;
         pub_ptr <= '0;
      end else begin
         if (wr_discard) begin
            wptr <= wcptr;
         end else begin
            wptr <= wptr_adv;
            if (wr_commit) wcptr <= wptr_adv;
         end
         // Walk the published pointer one word per cycle toward the
         // commit point so its Gray code never changes more than one bit.
         if (pub_ptr != wcptr) pub_ptr <= pub_ptr + 1'b1;
      end
   end

   // ---------------- read domain ----------------
   logic [PTR_W-1:0] rptr, wq_bin, rd_count;
   logic             pop_ok;

   assign rd_count      = wq_bin - rptr;
   assign pop_ok        = rd_pop && (rd_count != '0);
   assign rd_cell_avail = CMP_W'(rd_count) >= CMP_W'(cell_words);

   always_ff @(posedge rd_clk or posedge rst) begin
      if (rst)         rptr <= '0;
      else if (pop_ok) rptr <= rptr + 1'b1;
   end

   // ---------------- storage and crossings ----------------
   cellq_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
      .wr_clk (wr_clk),
      .we     (push_ok),
      .waddr  (wptr[ADDR_W-1:0]),
      .wdata  (wr_data),
      .raddr  (rptr[ADDR_W-1:0]),
      .rdata  (rd_data)
   );

   cellq_gray_xfer #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_pub_to_rd (
      .src_clk (wr_clk),
      .dst_clk (rd_clk),
      .rst     (rst),
      .src_bin (pub_ptr),
      .dst_bin (wq_bin)
   );

   cellq_gray_xfer #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_rd_to_wr (
      .src_clk (rd_clk),
      .dst_clk (wr_clk),
      .rst     (rst),
      .src_bin (rptr),
      .dst_bin (rq_bin)
   );

   // ---------------- assertions ----------------
   // R6
   wr_no_overrun_chk: assert property (@(posedge wr_clk) disable iff (rst)
      (wptr - rq_bin) <= DEPTH_P);

   // R3
   discard_rollback_chk: assert property (@(posedge wr_clk) disable iff (rst)
      wr_discard |=> (wptr == wcptr));

   // R8
   commit_discard_chk: assert property (@(posedge wr_clk) disable iff (rst)
      (wr_commit && wr_discard) |=> $stable(wcptr));

   // R2
   visible_lag_chk: assert property (@(posedge wr_clk) disable iff (rst)
      (wcptr - pub_ptr) <= DEPTH_P);

   // R7
   rd_empty_pop_chk: assert property (@(posedge rd_clk) disable iff (rst)
      (rd_pop && (rd_count == '0)) |=> $stable(rptr));
endmodule

// File: tb/cellq_dual_clock_bench.sv
module cellq_dual_clock_bench;
   localparam int DW = 16;
   localparam int AW = 7;

   logic          wr_clk = 1'b0;
   logic          rd_clk = 1'b0;
   logic          rst;
   logic [7:0]    cell_bytes;
   logic          wr_push, wr_commit, wr_discard;
   logic [DW-1:0] wr_data;
   logic          wr_room;
   logic          rd_pop;
   logic [DW-1:0] rd_data;
   logic          rd_cell_avail;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   always #5 wr_clk = ~wr_clk;
   always #7 rd_clk = ~rd_clk;

   cellq_dual_clock #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2), .CELL_BYTES_W(8))
   u_cellq_dual_clock (
      .rst           (rst),
      .cell_bytes    (cell_bytes),
      .wr_clk        (wr_clk),
      .wr_push       (wr_push),
      .wr_data       (wr_data),
      .wr_commit     (wr_commit),
      .wr_discard    (wr_discard),
      .wr_room       (wr_room),
      .rd_clk        (rd_clk),
      .rd_pop        (rd_pop),
      .rd_data       (rd_data),
      .rd_cell_avail (rd_cell_avail)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   task automatic push_words(input int n, input logic [DW-1:0] base, input bit commit_last);
      for (int i = 0; i < n; i++) begin
         @(negedge wr_clk);
         wr_push   = 1'b1;
         wr_data   = DW'(base + i);
         wr_commit = commit_last && (i == n - 1);
      end
      @(negedge wr_clk);
      wr_push   = 1'b0;
      wr_commit = 1'b0;
   endtask

   task automatic pulse_ctl(input bit c, input bit d);
      @(negedge wr_clk);
      wr_commit  = c;
      wr_discard = d;
      @(negedge wr_clk);
      wr_commit  = 1'b0;
      wr_discard = 1'b0;
   endtask

   task automatic settle();
      repeat (220) @(negedge wr_clk);
   endtask

   task automatic read_words(input int n, input logic [DW-1:0] base, input string req);
      for (int i = 0; i < n; i++) begin
         @(negedge rd_clk);
         check(req, 32'(rd_data), 32'(DW'(base + i)));
         rd_pop = 1'b1;
      end
      @(negedge rd_clk);
      rd_pop = 1'b0;
   endtask

   task automatic test_reset();
      // R1: flags right after reset release
      check("R1 avail", 32'(rd_cell_avail), 32'd0);
      check("R1 room", 32'(wr_room), 32'd1);
   endtask

   task automatic test_commit();
      cell_bytes = 8'd16;
      push_words(7, 16'h0100, 1'b0);
      settle();
      check("R2 uncommitted hidden", 32'(rd_cell_avail), 32'd0);
      // R9: commit rides on the last push
      push_words(1, 16'h0107, 1'b1);
      settle();
      check("R9 avail", 32'(rd_cell_avail), 32'd1);
      read_words(8, 16'h0100, "R2 data");
      settle();
      check("R4 drained", 32'(rd_cell_avail), 32'd0);
   endtask

   task automatic test_threshold();
      cell_bytes = 8'd17; // R4: odd bit ignored, 8 words
      push_words(4, 16'h0150, 1'b1);
      settle();
      check("R4 half cell", 32'(rd_cell_avail), 32'd0);
      push_words(4, 16'h0154, 1'b1);
      settle();
      check("R4 full cell", 32'(rd_cell_avail), 32'd1);
      read_words(8, 16'h0150, "R4 data");
      cell_bytes = 8'd16;
   endtask

   task automatic test_discard();
      push_words(8, 16'h0200, 1'b0);
      pulse_ctl(1'b0, 1'b1);
      settle();
      check("R3 dropped", 32'(rd_cell_avail), 32'd0);
      push_words(8, 16'h0280, 1'b1);
      settle();
      check("R3 next avail", 32'(rd_cell_avail), 32'd1);
      read_words(8, 16'h0280, "R3 data");
   endtask

   task automatic test_both();
      push_words(8, 16'h0300, 1'b0);
      pulse_ctl(1'b1, 1'b1);
      settle();
      check("R8 discard wins", 32'(rd_cell_avail), 32'd0);
      push_words(8, 16'h0380, 1'b1);
      settle();
      read_words(8, 16'h0380, "R8 data");
   endtask

   task automatic test_empty_pop();
      settle();
      @(negedge rd_clk);
      rd_pop = 1'b1;
      repeat (3) @(negedge rd_clk);
      rd_pop = 1'b0;
      push_words(8, 16'h0400, 1'b1);
      settle();
      check("R7 avail", 32'(rd_cell_avail), 32'd1);
      read_words(8, 16'h0400, "R7 data");
      settle();
      check("R7 drained", 32'(rd_cell_avail), 32'd0);
   endtask

   task automatic test_room();
      cell_bytes = 8'd128;
      settle();
      check("R5 empty room", 32'(wr_room), 32'd1);
      push_words(32, 16'h0500, 1'b1);
      settle();
      check("R10 32 words", 32'(rd_cell_avail), 32'd0);
      push_words(32, 16'h0520, 1'b1);
      settle();
      check("R10 64 words", 32'(rd_cell_avail), 32'd1);
      check("R5 half full", 32'(wr_room), 32'd1);
      push_words(10, 16'h0600, 1'b0);
      settle();
      check("R5 uncommitted", 32'(wr_room), 32'd1);
      pulse_ctl(1'b0, 1'b1);
      push_words(64, 16'h0700, 1'b1);
      settle();
      check("R5 full", 32'(wr_room), 32'd0);
      read_words(64, 16'h0500, "R10 data");
      settle();
      check("R5 freed", 32'(wr_room), 32'd1);
      read_words(64, 16'h0700, "R5 data");
      settle();
      check("R4 empty", 32'(rd_cell_avail), 32'd0);
   endtask

   task automatic test_overflow();
      cell_bytes = 8'd128;
      push_words(130, 16'h0A00, 1'b1);
      settle();
      check("R6 no room", 32'(wr_room), 32'd0);
      check("R6 avail", 32'(rd_cell_avail), 32'd1);
      read_words(128, 16'h0A00, "R6 data");
      settle();
      check("R6 drained", 32'(rd_cell_avail), 32'd0);
      check("R6 room back", 32'(wr_room), 32'd1);
      push_words(64, 16'h0B00, 1'b1);
      settle();
      read_words(64, 16'h0B00, "R6 next");
   endtask

   initial begin
      repeat (150000) @(posedge wr_clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog (all requirements): actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      rst        = 1'b1;
      cell_bytes = 8'd16;
      wr_push    = 1'b0;
      wr_commit  = 1'b0;
      wr_discard = 1'b0;
      wr_data    = '0;
      rd_pop     = 1'b0;
      repeat (5) @(negedge wr_clk);
      check("R1 avail in reset", 32'(rd_cell_avail), 32'd0);
      rst = 1'b0;
      repeat (3) @(negedge wr_clk);
      test_reset();
      test_commit();
      test_threshold();
      test_discard();
      test_both();
      test_empty_pop();
      test_room();
      test_overflow();
      done = 1'b1;
      summary();
      $finish;
   end
endmodule